// File: doc/BRIEF.md
# Snoop Coherency Cluster Coordinator

The coordinator runs coherent transactions for a cluster of four processors that share one snooped system bus. Any processor may present a read-exclusive or an upgrade request, tagged with a request number. The coordinator sends that request to every other processor as a snoop. A read-exclusive request goes out as an intervention-exclusive snoop. An upgrade request goes out as an invalidate snoop.

The coordinator waits until every processor other than the requester has returned a coherency state. It then combines those states and takes one of four paths:

- It grants bus mastership to the single owner of a dirty copy and passes that owner's data beats on to the requester.
- It supplies a stub memory block for a read-exclusive request that no cache holds dirty.
- It completes an upgrade straight away.
- It flags an error when more than one processor claims the line dirty.

Every transaction ends with one ACK completion. That ACK releases the request number, which stays busy from acceptance until that point.

Top module: `snoop_coord`

## Requirements
- R1: While `rst_ni` is low and at the first edges after reset, `req_ready_o` is 1 and all of these outputs are 0: `snp_valid_o`, `grant_o`, `blk_valid_o`, `ack_valid_o`, `err_num_o` and `err_multi_o`.
- R2: A request is accepted at the first edge where `req_valid_i` is high with the coordinator idle. In the next cycle, and only in that cycle, `snp_valid_o` is 1. `snp_tgt_o` then has bit p set for every processor except the requester. `snp_cmd_o` is 0 (intervention-exclusive) when `req_cmd_i` was 0 (read-exclusive), and 1 (invalidate) when `req_cmd_i` was 1 (upgrade).
- R3: Responses are collected only in the cycles after the broadcast cycle. A response from the requester itself is ignored, and so is a response given during the broadcast cycle. No grant, data, error or ACK appears until every non-requesting processor has responded. The decision follows in the cycle after the edge that captured the last missing response.
- R4: State codes are 2'b00 Invalid, 2'b01 Shared, 2'b10 CleanExclusive and 2'b11 DirtyExclusive. If exactly one responder reports 2'b11, `grant_o` holds that processor's one-hot bit from the cycle after the decision until the last data beat. During that time each `dat_valid_i` beat appears in the same cycle on `blk_valid_o`/`blk_data_o`, with `blk_mem_o`=0 and `blk_dst_o` equal to the requester. A transaction carries BEATS (4) beats, and gaps between beats are allowed.
- R5: One cycle after the last forwarded dirty beat, `ack_valid_o` is 1 for exactly one cycle. In that cycle `ack_num_o` carries the request number and `ack_dst_o` carries the requester.
- R6: An upgrade whose responses contain no 2'b11 issues the ACK in the cycle after the decision, with no grant and no data.
- R7: A read-exclusive whose responses contain no 2'b11 emits BEATS stub beats in consecutive cycles, starting the cycle after the decision. Each beat has `blk_mem_o`=1 and data equal to the beat index 0..BEATS-1. The ACK follows in the next cycle.
- R8: Two or more 2'b11 responses pulse `err_multi_o` in the decision cycle. No grant and no data follow, and the ACK is issued in the next cycle.
- R9: A request number is busy from acceptance until its ACK. A `req_valid_i` that carries a busy number raises `err_num_o` in the same cycle and is not accepted. `req_ready_o` is 0 while a transaction is in flight.
- R10: In the cycle after the ACK the coordinator is idle again, with `req_ready_o`=1. The released number can then be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Coherent request present |
| req_ready_o | output | 1 | Coordinator idle, request can be taken |
| req_src_i | input | 2 | Requesting processor |
| req_cmd_i | input | 1 | 0 read-exclusive, 1 upgrade |
| req_num_i | input | 2 | Request number |
| err_num_o | output | 1 | Presented request number is busy |
| snp_valid_o | output | 1 | Snoop broadcast cycle |
| snp_tgt_o | output | 4 | Processors addressed by the snoop |
| snp_cmd_o | output | 1 | 0 intervention-exclusive, 1 invalidate |
| rsp_valid_i | input | 4 | Per-processor coherency state response valid |
| rsp_state_i | input | 8 | Per-processor state, processor p at bits [2p+1:2p] |
| err_multi_o | output | 1 | More than one dirty owner reported |
| grant_o | output | 4 | One-hot bus mastership grant to the dirty owner |
| dat_valid_i | input | 1 | Data beat from the granted processor |
| dat_data_i | input | 32 | Data beat payload |
| blk_valid_o | output | 1 | Block data beat to the requester |
| blk_mem_o | output | 1 | Beat comes from the memory stub |
| blk_dst_o | output | 2 | Destination processor of the block data |
| blk_data_o | output | 32 | Block data beat payload |
| ack_valid_o | output | 1 | ACK completion |
| ack_dst_o | output | 2 | Processor receiving the ACK |
| ack_num_o | output | 2 | Request number released |

## Verification
Two things can happen in the same cycle. The busy-number check looks at whatever request is being presented, while the snoop broadcast of the accepted request is on the outputs. For some table rows the bench presents a second request in the broadcast cycle, first with the in-flight number and then with a free one. It then judges `err_num_o` and `req_ready_o` next to the snoop outputs of that same cycle. Other rows put all-dirty responses on the inputs during the broadcast cycle. The bench judges those as ignored when the later grant, stub or ACK path still follows only the responses that arrive in the collection window.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {
    CS_INV = 2'b00,
    CS_SHD = 2'b01,
    CS_CLN = 2'b10,
    CS_DRT = 2'b11
  } coh_state_e;

  typedef enum logic {
    CMD_RDX = 1'b0,
    CMD_UPG = 1'b1
  } req_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SNOOP,
    ST_COLLECT,
    ST_GRANT,
    ST_MEM,
    ST_ACK
  } crd_state_e;
endpackage

// File: rtl/snoop_rsp_collect.sv
module snoop_rsp_collect
  import snoop_pkg::*;
#(
  parameter int N_PROC = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                open_i,
  input  logic [N_PROC-1:0]   expect_i,
  input  logic [N_PROC-1:0]   rsp_valid_i,
  input  logic [2*N_PROC-1:0] rsp_state_i,
  output logic                done_o,
  output logic [N_PROC-1:0]   dirty_o
);
  logic [N_PROC-1:0] got_q;

  for (genvar p = 0; p < N_PROC; p++) begin : g_slot
    logic take;
    assign take = open_i && rsp_valid_i[p] && expect_i[p] && !got_q[p];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        got_q[p]   <= 1'b0;
        dirty_o[p] <= 1'b0;
      end else if (clear_i) begin
        got_q[p]   <= 1'b0;
        dirty_o[p] <= 1'b0;
      end else if (take) begin
        got_q[p]   <= 1'b1;
        dirty_o[p] <= (coh_state_e'(rsp_state_i[2*p +: 2]) == CS_DRT);
      end
    end
  end

  assign done_o = (got_q == expect_i);
endmodule

// File: rtl/snoop_reqnum_track.sv
module snoop_reqnum_track #(
  parameter int NUM_REQ = 4,
  localparam int RW = $clog2(NUM_REQ)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [RW-1:0] set_num_i,
  input  logic          clr_i,
  input  logic [RW-1:0] clr_num_i,
  input  logic [RW-1:0] chk_num_i,
  output logic          hit_o
);
  logic [NUM_REQ-1:0] busy_q, set_mask, clr_mask;

  assign set_mask = set_i ? (NUM_REQ'(1) << set_num_i) : '0;
  assign clr_mask = clr_i ? (NUM_REQ'(1) << clr_num_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= (busy_q | set_mask) & ~clr_mask;
  end

  assign hit_o = busy_q[chk_num_i];
endmodule

// File: rtl/snoop_beat_ctr.sv
module snoop_beat_ctr #(
  parameter int BEATS = 4,
  localparam int BW = $clog2(BEATS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [BW-1:0] cnt_o,
  output logic          last_o
);
  assign last_o = (cnt_o == BW'(BEATS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= last_o ? '0 : cnt_o + 1'b1;
  end
endmodule

// File: rtl/snoop_coord.sv
module snoop_coord
  import snoop_pkg::*;
#(
  parameter int N_PROC  = 4,
  parameter int NUM_REQ = 4,
  parameter int DATA_W  = 32,
  parameter int BEATS   = 4,
  localparam int PW = $clog2(N_PROC),
  localparam int RW = $clog2(NUM_REQ),
  localparam int BW = $clog2(BEATS),
  localparam int CW = $clog2(N_PROC + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [PW-1:0]       req_src_i,
  input  logic                req_cmd_i,
  input  logic [RW-1:0]       req_num_i,
  output logic                err_num_o,
  output logic                snp_valid_o,
  output logic [N_PROC-1:0]   snp_tgt_o,
  output logic                snp_cmd_o,
  input  logic [N_PROC-1:0]   rsp_valid_i,
  input  logic [2*N_PROC-1:0] rsp_state_i,
  output logic                err_multi_o,
  output logic [N_PROC-1:0]   grant_o,
  input  logic                dat_valid_i,
  input  logic [DATA_W-1:0]   dat_data_i,
  output logic                blk_valid_o,
  output logic                blk_mem_o,
  output logic [PW-1:0]       blk_dst_o,
  output logic [DATA_W-1:0]   blk_data_o,
  output logic                ack_valid_o,
  output logic [PW-1:0]       ack_dst_o,
  output logic [RW-1:0]       ack_num_o
);
  crd_state_e        state_q, state_d;
  logic [PW-1:0]     src_q;
  req_cmd_e          cmd_q;
  logic [RW-1:0]     num_q;
  logic              accept, num_busy, all_in, last_beat, beat_inc;
  logic [N_PROC-1:0] expect_mask, dirty;
  logic [CW-1:0]     n_dirty;
  logic [BW-1:0]     beat;

  assign expect_mask = ~(N_PROC'(1) << src_q);
  assign req_ready_o = (state_q == ST_IDLE);
  assign err_num_o   = req_valid_i && num_busy;
  assign accept      = req_valid_i && req_ready_o && !num_busy;

  snoop_reqnum_track #(.NUM_REQ(NUM_REQ)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (accept),
    .set_num_i (req_num_i),
    .clr_i     (ack_valid_o),
    .clr_num_i (num_q),
    .chk_num_i (req_num_i),
    .hit_o     (num_busy)
  );

  snoop_rsp_collect #(.N_PROC(N_PROC)) u_collect (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (accept),
    .open_i      (state_q == ST_COLLECT),
    .expect_i    (expect_mask),
    .rsp_valid_i (rsp_valid_i),
    .rsp_state_i (rsp_state_i),
    .done_o      (all_in),
    .dirty_o     (dirty)
  );

  assign beat_inc = (state_q == ST_MEM) || (state_q == ST_GRANT && dat_valid_i);

  snoop_beat_ctr #(.BEATS(BEATS)) u_beat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .inc_i  (beat_inc),
    .cnt_o  (beat),
    .last_o (last_beat)
  );

  always_comb begin
    n_dirty = '0;
    for (int p = 0; p < N_PROC; p++) n_dirty += CW'(dirty[p]);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = ST_SNOOP;
      ST_SNOOP:   state_d = ST_COLLECT;
      ST_COLLECT: if (all_in) begin
        if (n_dirty > CW'(1))       state_d = ST_ACK;
        else if (n_dirty == CW'(1)) state_d = ST_GRANT;
        else if (cmd_q == CMD_RDX)  state_d = ST_MEM;
        else                        state_d = ST_ACK;
      end
      ST_GRANT:   if (dat_valid_i && last_beat) state_d = ST_ACK;
      ST_MEM:     if (last_beat) state_d = ST_ACK;
      ST_ACK:     state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      cmd_q   <= CMD_RDX;
      num_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        src_q <= req_src_i;
        cmd_q <= req_cmd_e'(req_cmd_i);
        num_q <= req_num_i;
      end
    end
  end

  assign snp_valid_o = (state_q == ST_SNOOP);
  assign snp_tgt_o   = snp_valid_o ? expect_mask : '0;
  assign snp_cmd_o   = (cmd_q == CMD_UPG);

  assign err_multi_o = (state_q == ST_COLLECT) && all_in && (n_dirty > CW'(1));
  assign grant_o     = (state_q == ST_GRANT) ? dirty : '0;

  assign blk_valid_o = beat_inc;
  assign blk_mem_o   = (state_q == ST_MEM);
  assign blk_dst_o   = src_q;
  assign blk_data_o  = blk_mem_o ? DATA_W'(beat) : dat_data_i;

  assign ack_valid_o = (state_q == ST_ACK);
  assign ack_dst_o   = src_q;
  assign ack_num_o   = num_q;
endmodule

// File: rtl/snoop_coord_chk.sv
module snoop_coord_chk #(
  parameter int N_PROC  = 4,
  parameter int NUM_REQ = 4,
  parameter int DATA_W  = 32,
  localparam int PW = $clog2(N_PROC),
  localparam int RW = $clog2(NUM_REQ)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_ready_o,
  input logic                err_num_o,
  input logic                snp_valid_o,
  input logic [N_PROC-1:0]   snp_tgt_o,
  input logic                err_multi_o,
  input logic [N_PROC-1:0]   grant_o,
  input logic                blk_valid_o,
  input logic                blk_mem_o,
  input logic                ack_valid_o,
  input logic [RW-1:0]       ack_num_o,
  input logic [PW-1:0]       ack_dst_o
);
  // R2
  snoop_targets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_o |-> $countones(snp_tgt_o) == N_PROC - 1);
  // R2
  snoop_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_o |=> !snp_valid_o);
  // R4
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  // R4
  owner_data_granted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_valid_o && !blk_mem_o) |-> grant_o != '0);
  // R5
  no_ack_under_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0) |-> !ack_valid_o);
  // R8
  multi_no_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_multi_o |=> (grant_o == '0 && !blk_valid_o && ack_valid_o));
  // R9
  busy_num_inflight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_num_o |-> !req_ready_o);
  // R10
  ack_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |=> (req_ready_o && !ack_valid_o));
endmodule

bind snoop_coord snoop_coord_chk #(
  .N_PROC (N_PROC),
  .NUM_REQ(NUM_REQ),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .err_num_o   (err_num_o),
  .snp_valid_o (snp_valid_o),
  .snp_tgt_o   (snp_tgt_o),
  .err_multi_o (err_multi_o),
  .grant_o     (grant_o),
  .blk_valid_o (blk_valid_o),
  .blk_mem_o   (blk_mem_o),
  .ack_valid_o (ack_valid_o),
  .ack_num_o   (ack_num_o),
  .ack_dst_o   (ack_dst_o)
);

// File: tb/tb_snoop_coord.sv
`timescale 1ns/1ps
module tb_snoop_coord;
  localparam int N = 4, NR = 4, DW = 32, BEATS = 4;
  localparam int NROWS = 8;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          req_valid_i = 1'b0, req_ready_o, req_cmd_i = 1'b0;
  logic [1:0]    req_src_i = '0, req_num_i = '0;
  logic          err_num_o, snp_valid_o, snp_cmd_o, err_multi_o;
  logic [N-1:0]  snp_tgt_o, grant_o, rsp_valid_i = '0;
  logic [2*N-1:0] rsp_state_i = '0;
  logic          dat_valid_i = 1'b0;
  logic [DW-1:0] dat_data_i = '0, blk_data_o;
  logic          blk_valid_o, blk_mem_o, ack_valid_o;
  logic [1:0]    blk_dst_o, ack_dst_o, ack_num_o;

  int checks = 0, failures = 0;

  snoop_coord dut (.*);

  always #2.5 clk_i = ~clk_i;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // src, cmd, num, states{p3,p2,p1,p0}, kind(0 ack,1 grant,2 mem,3 multi), grant, stagger, noise, probe
  localparam logic [21:0] VEC [NROWS] = '{
    {2'd0, 1'b0, 2'd0, 8'b00_11_00_00, 2'd1, 4'b0100, 3'b000},
    {2'd0, 1'b1, 2'd1, 8'b01_01_00_00, 2'd0, 4'b0000, 3'b001},
    {2'd3, 1'b0, 2'd1, 8'b00_10_00_01, 2'd2, 4'b0000, 3'b100},
    {2'd1, 1'b0, 2'd3, 8'b00_11_00_11, 2'd3, 4'b0000, 3'b000},
    {2'd2, 1'b1, 2'd0, 8'b00_00_00_00, 2'd0, 4'b0000, 3'b010},
    {2'd2, 1'b0, 2'd2, 8'b11_00_01_00, 2'd1, 4'b1000, 3'b101},
    {2'd1, 1'b1, 2'd3, 8'b01_01_00_11, 2'd1, 4'b0001, 3'b010},
    {2'd3, 1'b1, 2'd2, 8'b00_00_01_10, 2'd0, 4'b0000, 3'b000}
  };

  task automatic run_txn(input int row, input logic [21:0] v);
    logic [1:0] src, num, kind;
    logic cmd, stagger, noise, probe;
    logic [7:0] st;
    logic [3:0] gnt, tgt;
    int lastp;
    string ack_tag;
    src = v[21:20]; cmd = v[19]; num = v[18:17]; st = v[16:9];
    kind = v[8:7]; gnt = v[6:3]; stagger = v[2]; noise = v[1]; probe = v[0];
    st[src*2 +: 2] = 2'b11;  // requester claims dirty: must be ignored (R3)
    tgt = 4'hF & ~(4'b1 << src);
    lastp = (src == 2'd3) ? 2 : 3;

    @(negedge clk_i);
    check("R10 idle before request", req_ready_o, 1);
    req_valid_i = 1'b1; req_src_i = src; req_cmd_i = cmd; req_num_i = num;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check("R2 snoop valid", snp_valid_o, 1);
    check("R2 snoop targets", snp_tgt_o, tgt);
    check("R2 snoop command", snp_cmd_o, cmd);
    check("R9 ready low in flight", req_ready_o, 0);
    if (probe) begin
      req_valid_i = 1'b1; req_num_i = num; #0.5;
      check("R9 busy number flagged", err_num_o, 1);
      req_num_i = num ^ 2'd1; #0.5;
      check("R9 free number not flagged", err_num_o, 0);
      req_valid_i = 1'b0;
    end
    if (noise) begin rsp_valid_i = 4'hF; rsp_state_i = 8'hFF; end
    @(negedge clk_i);
    check("R2 snoop one cycle", snp_valid_o, 0);
    if (!stagger) begin
      rsp_valid_i = 4'hF; rsp_state_i = st;
      @(negedge clk_i);
      rsp_valid_i = '0;
    end else begin
      rsp_valid_i = '0;
      for (int p = 0; p < N; p++) begin
        rsp_valid_i = 4'b1 << p; rsp_state_i = st;
        @(negedge clk_i);
        rsp_valid_i = '0;
        if (p != lastp) begin
          check("R3 no action before all responses",
                {grant_o, blk_valid_o, ack_valid_o, err_multi_o}, 0);
        end else break;
      end
    end
    check("R8 multi-dirty error in decision cycle", err_multi_o, kind == 2'd3);
    check("R3 no grant in decision cycle", grant_o, 0);
    @(negedge clk_i);
    case (kind)
      2'd1: begin
        ack_tag = "R5 ack after dirty data";
        for (int b = 0; b < BEATS; b++) begin
          if (b == 2) begin
            dat_valid_i = 1'b0; #0.5;
            check("R5 no ack during beat gap", {blk_valid_o, ack_valid_o}, 0);
            @(negedge clk_i);
          end
          check("R4 grant to dirty owner", grant_o, gnt);
          dat_valid_i = 1'b1; dat_data_i = 32'hA000_0000 | (row << 8) | b; #0.5;
          check("R4 beat forwarded", {blk_valid_o, blk_mem_o, blk_dst_o}, {1'b1, 1'b0, src});
          check("R4 beat data", blk_data_o, 32'hA000_0000 | (row << 8) | b);
          @(negedge clk_i);
        end
        dat_valid_i = 1'b0;
      end
      2'd2: begin
        ack_tag = "R7 ack after stub";
        for (int b = 0; b < BEATS; b++) begin
          check("R7 stub beat", {blk_valid_o, blk_mem_o, blk_dst_o, grant_o}, {1'b1, 1'b1, src, 4'b0});
          check("R7 stub data", blk_data_o, b);
          @(negedge clk_i);
        end
      end
      2'd3: begin
        ack_tag = "R8 ack after error";
        check("R8 no grant no data", {grant_o, blk_valid_o}, 0);
      end
      default: begin
        ack_tag = "R6 upgrade ack";
        check("R6 no grant no data", {grant_o, blk_valid_o}, 0);
      end
    endcase
    check(ack_tag, {ack_valid_o, ack_num_o, ack_dst_o}, {1'b1, num, src});
    @(negedge clk_i);
    check("R10 idle after ack", {ack_valid_o, req_ready_o}, 2'b01);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL R10 watchdog actual=hung expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    check("R1 reset ready", req_ready_o, 1);
    check("R1 reset outputs quiet",
          {snp_valid_o, grant_o, blk_valid_o, ack_valid_o, err_num_o, err_multi_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 quiet after reset",
          {snp_valid_o, grant_o, blk_valid_o, ack_valid_o, err_num_o, err_multi_o, req_ready_o}, 1);

    for (int r = 0; r < NROWS; r++) run_txn(r, VEC[r]);

    // released number is accepted again right after its ACK (R10, R9)
    @(negedge clk_i);
    req_valid_i = 1'b1; req_src_i = 2'd0; req_cmd_i = 1'b1; req_num_i = 2'd2;
    #0.5;
    check("R9 released number not busy", err_num_o, 0);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check("R10 released number accepted", snp_valid_o, 1);
    @(negedge clk_i);
    rsp_valid_i = 4'hE; rsp_state_i = 8'b00_01_00_00;
    @(negedge clk_i);
    rsp_valid_i = '0;
    @(negedge clk_i);
    check("R6 ack for reused number", {ack_valid_o, ack_num_o}, {1'b1, 2'd2});
    @(negedge clk_i);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule